// File: doc/BRIEF.md
# Datapath ALU with Output Shifter

This block is the arithmetic heart of a microprogrammed datapath. It takes a left operand from a holding register and a right operand from a shared source bus. It combines them under a set of raw control lines and passes the outcome through a small fixed shifter onto the result bus. The block is purely combinational, so a result is valid in the same cycle that its operands and controls are presented.

Control works without an opcode. Two select lines choose among AND, OR, complement-of-right and addition. Separate lines then condition the operands:
- Each operand has its own gate, which forces that operand to zero when low.
- A third line complements the left operand.
- A fourth line injects a carry of one into the addition.

Two shift lines choose between a one-byte logical left shift and a one-bit arithmetic right shift of the result. Negative and zero status bits are taken from the unshifted result, so a microprogram can branch on the function outcome whatever shift it applies.

Top module: `alu_shift_datapath`

## Requirements
- R1: The select `f_sel` picks the function as 2'b00 = left AND right, 2'b01 = left OR right, 2'b10 = bitwise complement of the right operand, 2'b11 = left plus right (modulo 2^DATA_W).
- R2: When `en_a` is low the left operand entering the function is zero, and when `en_b` is low the right operand entering the function is zero. Each gate acts independently of the other.
- R3: When `inv_a` is high the gated left operand is bitwise complemented before the function. A disabled left operand therefore becomes all ones.
- R4: When `inc` is high and `f_sel` is 2'b11, one is added to the sum. For every other `f_sel` value, `inc` has no effect on any output.
- R5: With `f_sel` = 2'b11, `en_a` low, `en_b` high, `inv_a` low, `inc` low and no shift, `c_out` equals `b_in`.
- R6: With `sh_left8` high and `sh_right1` low, `c_out` is the function result shifted left by 8 bits, and its low 8 bits are zero.
- R7: With `sh_right1` high and `sh_left8` low, `c_out` is the function result shifted right by one bit, with bit DATA_W-1 copied from the result's own top bit.
- R8: With both shift lines high, or both low, `c_out` equals the unshifted function result.
- R9: `n_flag` equals bit DATA_W-1 of the unshifted function result, whatever shift is selected.
- R10: `z_flag` is high exactly when the unshifted function result is all zeros, whatever shift is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | DATA_W | Left operand from the holding register |
| b_in | input | DATA_W | Right operand from the source bus |
| f_sel | input | 2 | Function select (see R1) |
| en_a | input | 1 | Left operand enable |
| en_b | input | 1 | Right operand enable |
| inv_a | input | 1 | Complement the gated left operand |
| inc | input | 1 | Carry-in of one for the addition |
| sh_left8 | input | 1 | Shift the result left by one byte |
| sh_right1 | input | 1 | Arithmetic shift of the result right by one bit |
| c_out | output | DATA_W | Shifted result driven to the result bus |
| n_flag | output | 1 | Negative status of the unshifted result |
| z_flag | output | 1 | Zero status of the unshifted result |

## Verification
Some properties are checked whenever the inputs change, comparing the blocks against each other:
- the zeroed low byte after a left shift;
- the copied sign bit after a right shift;
- the equality of the output and the unshifted result when no shift is selected;
- the right-operand pass-through;
- the all-ones complement of a disabled right operand;
- the flags' dependence on the unshifted result.

Exact arithmetic values can only be shown by the bench's scenarios, which compare every output against a behavioural model:
- carry-in at sum wrap-around;
- the complemented-left subtraction idiom;
- the inertness of the carry line outside addition;
- the flags under a shift that changes the sign or the zero state.

// File: rtl/alu_pkg.sv
package alu_pkg;
  parameter int DATA_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_BOTH  = 2'b11
  } shift_sel_e;
endpackage

// File: rtl/alu_operand_gate.sv
module alu_operand_gate #(
  parameter int W = alu_pkg::DATA_W
) (
  input  logic [W-1:0] a_raw,
  input  logic [W-1:0] b_raw,
  input  logic         en_a,
  input  logic         en_b,
  input  logic         inv_a,
  output logic [W-1:0] a_op,
  output logic [W-1:0] b_op
);
  logic [W-1:0] a_gated;

  always_comb begin
    a_gated = en_a ? a_raw : '0;
    a_op    = inv_a ? ~a_gated : a_gated;
    b_op    = en_b ? b_raw : '0;
  end

  // R3
  always_comb begin
    if (!en_a && inv_a) begin
      disabled_inverted_chk: assert (a_op == {W{1'b1}});
    end
  end
endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit
  import alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_op,
  input  logic [W-1:0] b_op,
  input  alu_fn_e      fn,
  input  logic         carry_in,
  output logic [W-1:0] res
);
  logic [W-1:0] sum;
  logic [W-1:0] cin_vec;

  always_comb begin
    cin_vec = '0;
    cin_vec[0] = carry_in & (fn == FN_ADD);
    sum = a_op + b_op + cin_vec;
    unique case (fn)
      FN_AND:  res = a_op & b_op;
      FN_OR:   res = a_op | b_op;
      FN_NOTB: res = ~b_op;
      FN_ADD:  res = sum;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_out_shifter.sv
module alu_out_shifter
  import alu_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int LSHIFT = BYTE_W
) (
  input  logic [W-1:0] din,
  input  logic         left_en,
  input  logic         right_en,
  output logic [W-1:0] dout
);
  shift_sel_e sel;

  always_comb begin
    sel = shift_sel_e'({left_en, right_en});
    unique case (sel)
      SH_LEFT:  dout = {din[W-LSHIFT-1:0], {LSHIFT{1'b0}}};
      SH_RIGHT: dout = {din[W-1], din[W-1:1]};
      default:  dout = din;
    endcase
  end

  // R6
  always_comb begin
    if (left_en && !right_en) begin
      left_fill_chk: assert (dout[LSHIFT-1:0] == '0);
    end
  end

  // R7
  always_comb begin
    if (right_en && !left_en) begin
      sign_keep_chk: assert (dout[W-1] == din[W-1] && dout[W-2:0] == din[W-1:1]);
    end
  end
endmodule

// File: rtl/alu_shift_datapath.sv
module alu_shift_datapath
  import alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   f_sel,
  input  logic         en_a,
  input  logic         en_b,
  input  logic         inv_a,
  input  logic         inc,
  input  logic         sh_left8,
  input  logic         sh_right1,
  output logic [W-1:0] c_out,
  output logic         n_flag,
  output logic         z_flag
);
  logic [W-1:0] a_op;
  logic [W-1:0] b_op;
  logic [W-1:0] alu_res;
  alu_fn_e      fn;

  assign fn = alu_fn_e'(f_sel);

  alu_operand_gate #(.W(W)) u_gate (
    .a_raw(a_in), .b_raw(b_in), .en_a(en_a), .en_b(en_b), .inv_a(inv_a),
    .a_op(a_op), .b_op(b_op)
  );

  alu_func_unit #(.W(W)) u_func (
    .a_op(a_op), .b_op(b_op), .fn(fn), .carry_in(inc), .res(alu_res)
  );

  alu_out_shifter #(.W(W), .LSHIFT(BYTE_W)) u_shift (
    .din(alu_res), .left_en(sh_left8), .right_en(sh_right1), .dout(c_out)
  );

  always_comb begin
    n_flag = alu_res[W-1];
    z_flag = ~|alu_res;
  end

  // R5
  always_comb begin
    if (fn == FN_ADD && !en_a && en_b && !inv_a && !inc && !sh_left8 && !sh_right1) begin
      pass_b_chk: assert (c_out == b_in);
    end
  end

  // R8
  always_comb begin
    if (sh_left8 == sh_right1) begin
      no_shift_chk: assert (c_out == alu_res);
    end
  end

  // R2
  always_comb begin
    if (fn == FN_NOTB && !en_b) begin
      right_gate_chk: assert (alu_res == {W{1'b1}});
    end
  end

  // R10
  always_comb begin
    if (sh_left8 == sh_right1) begin
      zero_flag_chk: assert (z_flag == (c_out == '0));
    end
  end

  // R9
  always_comb begin
    if (sh_left8 == sh_right1) begin
      neg_flag_chk: assert (n_flag == c_out[W-1]);
    end
  end
endmodule

// File: tb/sim_alu_shift_datapath.sv
`timescale 1ns/1ps
module sim_alu_shift_datapath;
  localparam int W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a_in, b_in, c_out;
  logic [1:0]   f_sel;
  logic en_a, en_b, inv_a, inc, sh_left8, sh_right1, n_flag, z_flag;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  alu_shift_datapath u0 (
    .a_in(a_in), .b_in(b_in), .f_sel(f_sel), .en_a(en_a), .en_b(en_b),
    .inv_a(inv_a), .inc(inc), .sh_left8(sh_left8), .sh_right1(sh_right1),
    .c_out(c_out), .n_flag(n_flag), .z_flag(z_flag)
  );

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] f, input bit ea, input bit eb,
                       input bit ia, input bit ci, input bit sl, input bit sr,
                       input string tag);
    longint unsigned lhs, rhs, raw, mask;
    logic [W-1:0] expr, expc;
    bit expn, expz;
    mask = (64'd1 << W) - 1;
    @(posedge clk);
    #1;
    a_in = a; b_in = b; f_sel = f; en_a = ea; en_b = eb;
    inv_a = ia; inc = ci; sh_left8 = sl; sh_right1 = sr;
    lhs = ea ? longint'(a) : 0;
    if (ia) lhs = (~lhs) & mask;
    rhs = eb ? longint'(b) : 0;
    if (f == 2'd0)      raw = lhs & rhs;
    else if (f == 2'd1) raw = lhs | rhs;
    else if (f == 2'd2) raw = (~rhs) & mask;
    else                raw = (lhs + rhs + (ci ? 1 : 0)) & mask;
    expr = raw[W-1:0];
    expn = expr[W-1];
    expz = (raw == 0);
    if (sl && !sr)      expc = expr << 8;
    else if (sr && !sl) expc = W'(raw >> 1) | (expn ? {1'b1, {(W-1){1'b0}}} : '0);
    else                expc = expr;
    @(negedge clk);
    vectors++;
    if (c_out !== expc || n_flag !== expn || z_flag !== expz) begin
      errors++;
      $display("FAIL %s: c=%h n=%b z=%b expected c=%h n=%b z=%b",
               tag, c_out, n_flag, z_flag, expc, expn, expz);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    a_in = '0; b_in = '0; f_sel = '0; en_a = 0; en_b = 0;
    inv_a = 0; inc = 0; sh_left8 = 0; sh_right1 = 0;
    // idle state: all controls low gives zero result with Z set (R10)
    apply(0, 0, 2'b00, 0, 0, 0, 0, 0, 0, "R10 idle");
    // R1 each function
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 2'b00, 1, 1, 0, 0, 0, 0, "R1 and");
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 2'b01, 1, 1, 0, 0, 0, 0, "R1 or");
    apply(32'hF0F0_1234, 32'h0FF0_FF00, 2'b10, 1, 1, 0, 0, 0, 0, "R1 notb");
    apply(32'h7FFF_FFFF, 32'h0000_0001, 2'b11, 1, 1, 0, 0, 0, 0, "R1 add overflow");
    // R2 gating
    apply(32'hDEAD_BEEF, 32'h1234_5678, 2'b01, 0, 1, 0, 0, 0, 0, "R2 en_a low");
    apply(32'hDEAD_BEEF, 32'h1234_5678, 2'b01, 1, 0, 0, 0, 0, 0, "R2 en_b low");
    apply(32'hDEAD_BEEF, 32'h1234_5678, 2'b10, 1, 0, 0, 0, 0, 0, "R2 notb disabled");
    // R3 invert
    apply(32'h0000_00FF, 32'hFFFF_FFFF, 2'b00, 1, 1, 1, 0, 0, 0, "R3 inv and");
    apply(32'h1111_1111, 32'h0, 2'b01, 0, 1, 1, 0, 0, 0, "R3 inv disabled");
    apply(32'd5, 32'd9, 2'b11, 1, 1, 1, 1, 0, 0, "R3 b minus a");
    // R4 carry
    apply(32'hFFFF_FFFF, 32'h0, 2'b11, 1, 1, 0, 1, 0, 0, "R4 wrap");
    apply(32'h0, 32'h0, 2'b11, 0, 0, 0, 1, 0, 0, "R4 one");
    apply(32'hAAAA_0000, 32'h5555_0000, 2'b00, 1, 1, 0, 1, 0, 0, "R4 ignored and");
    apply(32'h0, 32'hFFFF_FFFF, 2'b10, 1, 1, 0, 1, 0, 0, "R4 ignored notb");
    // R5 pass-through
    apply(32'hCAFE_F00D, 32'h8765_4321, 2'b11, 0, 1, 0, 0, 0, 0, "R5 pass b");
    // R6 left shift
    apply(32'h0, 32'h8123_45FF, 2'b11, 0, 1, 0, 0, 1, 0, "R6 sll8");
    // R7 right shift
    apply(32'h0, 32'h8000_0003, 2'b11, 0, 1, 0, 0, 0, 1, "R7 sra neg");
    apply(32'h0, 32'h4000_0002, 2'b11, 0, 1, 0, 0, 0, 1, "R7 sra pos");
    // R8 both shifts
    apply(32'h0, 32'h8123_4567, 2'b11, 0, 1, 0, 0, 1, 1, "R8 both");
    // R9 / R10 flags before the shifter
    apply(32'h0, 32'h0080_0000, 2'b11, 0, 1, 0, 0, 1, 0, "R9 n pre-shift");
    apply(32'h0, 32'hFF00_0000, 2'b11, 0, 1, 0, 0, 1, 0, "R10 z pre-shift");
    apply(32'h0, 32'h0000_0001, 2'b11, 0, 1, 0, 0, 0, 1, "R10 z sra");
    for (int i = 0; i < 400; i++) begin
      apply($urandom, $urandom, 2'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R1 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule